// File: doc/BRIEF.md
# Multiplexed DRAM Controller with RAS-Only Refresh

This block connects a video display engine to a 16K x 8 dynamic memory array that has a single multiplexed address bus. The engine presents one read or write request at a time: a 14-bit word address and, for writes, 8 bits of data. The controller runs each access as a row phase and then a column phase. The row half of the address is driven with RAS active. After a programmable delay, the column half is driven with CAS active. The direction line selects whether the memory is read or written. Read data comes back on a one-cycle valid strobe.

The block keeps the array's contents alive by itself. A free-running interval timer owes one refresh per period. Each refresh is a RAS-only cycle: a row counter is placed on the address bus, RAS is pulsed, and CAS stays inactive. Owed refreshes are served ahead of new requests.

At the end of each raster scan the engine pulses a frame-end input. The controller answers with a one-cycle interrupt to the host and queues a burst of refreshes. This burst uses the vertical blanking gap, so the host can then update the memory without competing with refresh.

Top module: `dram_refresh_ctl`

## Requirements
- R1: After reset, dramRasN and dramCasN are high, reqReady is high, rdValid is low and hostIrq is low.
- R2: An access drives the row (reqAddr[13:7]) on dramAddr when dramRasN falls. It then drives the column (reqAddr[6:0], zero-extended) when dramCasN falls. RAS stays low for at least RCD_CLKS clocks before CAS falls.
- R3: During the column phase, dramRw is 1 for a read and 0 for a write, and a write drives its data on dramDout. For a read, rdData shows the stored byte while rdValid is high for one cycle, so a read returns the last value written to that address.
- R4: Between any two RAS-low periods, dramRasN stays high for at least PRE_CLKS clocks.
- R5: A refresh holds dramCasN high for its whole RAS-low period and drives the refresh row counter on dramAddr. The counter starts at 0 after reset and steps by one per refresh, wrapping from 127 to 0.
- R6: The controller owes one refresh every REF_INTERVAL clocks, so an otherwise idle controller performs about one refresh per interval.
- R7: An owed refresh is started before the next access is accepted, and it waits no longer than the end of the access in progress.
- R8: A frameEnd pulse raises hostIrq for exactly the following cycle and queues BURST_LEN refreshes. All of them finish before a request issued after the pulse is served.
- R9: reqReady is high only when the controller is idle and owes no refresh; a request is taken only when reqValid and reqReady are both high.
- R10: dramCasN is never low while dramRasN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken this cycle if reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 14 | Word address, row in [13:7], column in [6:0] |
| reqWData | input | 8 | Write data |
| rdValid | output | 1 | One-cycle read data strobe |
| rdData | output | 8 | Read data |
| frameEnd | input | 1 | End-of-raster pulse |
| hostIrq | output | 1 | One-cycle interrupt to the host |
| dramAddr | output | 7 | Multiplexed row/column/refresh address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramRw | output | 1 | 1 = read, 0 = write |
| dramDout | output | 8 | Data to memory |
| dramDoe | output | 1 | Data output enable during writes |
| dramDin | input | 8 | Data from memory |

## Verification
The bench builds the controller with a refresh interval of 40 clocks, a burst length of 5, RAS-to-CAS and precharge of 2 clocks and a refresh pulse of 3 clocks. The short interval lets an idle window of a few hundred cycles show the refresh rate. It also lets the refresh row counter wrap past 127 in about five thousand cycles. The burst of 5 is long enough that a request issued right after frameEnd must wait behind several RAS-only cycles. A behavioural memory model checks row and column order, strobe spacing and refresh rows at the pins.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } ctlState_t;

  typedef struct packed {
    logic load;     // latch request fields
    logic rasOn;    // row strobe active
    logic casOn;    // column strobe active
    logic useCol;   // drive column half
    logic useRef;   // drive refresh row
    logic capture;  // sample read data
    logic refInc;   // advance refresh row
  } ctlStrobe_t;

endpackage

// File: rtl/dram_ctl_fsm.sv
module dram_ctl_fsm
  import dram_ctl_pkg::*;
#(
  parameter int RCD_CLKS     = 2,
  parameter int CAS_CLKS     = 2,
  parameter int PRE_CLKS     = 2,
  parameter int REF_CLKS     = 3,
  parameter int REF_INTERVAL = 390,
  parameter int BURST_LEN    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       frameEnd,
  output logic       reqReady,
  output logic       hostIrq,
  output ctlStrobe_t stb
);
  localparam int TMAX    = RCD_CLKS + CAS_CLKS + PRE_CLKS + REF_CLKS;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int IW      = $clog2(REF_INTERVAL + 1);
  localparam int OW      = $clog2(BURST_LEN + 2) + 1;
  localparam int OMAX    = (1 << OW) - 1;
  localparam int MAXWAIT = RCD_CLKS + CAS_CLKS + PRE_CLKS + 1;

  ctlState_t       state;
  logic [TW-1:0]   timer;
  logic [IW-1:0]   ivl;
  logic [OW-1:0]   owed;
  logic [OW-1:0]   owedNext;
  logic            tick, take, accept, tEnd;
  int              owedSum;

  assign tick     = (ivl == '0);
  assign tEnd     = (timer == '0);
  assign reqReady = (state == ST_IDLE) && (owed == '0);
  assign take     = (state == ST_IDLE) && (owed != '0);
  assign accept   = reqReady && reqValid;

  always_comb begin
    owedSum = int'(owed) + (tick ? 1 : 0) + (frameEnd ? BURST_LEN : 0)
              - (take ? 1 : 0);
    owedNext = (owedSum > OMAX) ? OW'(OMAX) : OW'(owedSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivl     <= IW'(REF_INTERVAL - 1);
      owed    <= '0;
      hostIrq <= 1'b0;
    end else begin
      ivl     <= tick ? IW'(REF_INTERVAL - 1) : ivl - 1'b1;
      owed    <= owedNext;
      hostIrq <= frameEnd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            state <= ST_REF;
            timer <= TW'(REF_CLKS - 1);
          end else if (accept) begin
            state <= ST_ROW;
            timer <= TW'(RCD_CLKS - 1);
          end
        end
        ST_ROW: begin
          if (tEnd) begin
            state <= ST_COL;
            timer <= TW'(CAS_CLKS - 1);
          end else timer <= timer - 1'b1;
        end
        ST_COL, ST_REF: begin
          if (tEnd) begin
            state <= ST_PRE;
            timer <= TW'(PRE_CLKS - 1);
          end else timer <= timer - 1'b1;
        end
        ST_PRE: begin
          if (tEnd) state <= ST_IDLE;
          else timer <= timer - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.load    = accept;
    stb.rasOn   = (state == ST_ROW) || (state == ST_COL) || (state == ST_REF);
    stb.casOn   = (state == ST_COL);
    stb.useCol  = (state == ST_COL);
    stb.useRef  = (state == ST_REF);
    stb.capture = (state == ST_COL) && tEnd;
    stb.refInc  = (state == ST_REF) && tEnd;
  end

  // Strobe spacing monitors for the assertions below
  logic [TW-1:0] rasLowCnt, rasHighCnt;
  logic [TW:0]   waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasLowCnt  <= '0;
      rasHighCnt <= TW'(PRE_CLKS);
      waitCnt    <= '0;
    end else begin
      rasLowCnt  <= !stb.rasOn ? '0 : (rasLowCnt == '1 ? rasLowCnt : rasLowCnt + 1'b1);
      rasHighCnt <= stb.rasOn ? '0 : (rasHighCnt == '1 ? rasHighCnt : rasHighCnt + 1'b1);
      waitCnt    <= (owed != '0 && state != ST_REF) ? waitCnt + 1'b1 : '0;
    end
  end

  // R2
  rcd_met_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.casOn) |-> rasLowCnt >= TW'(RCD_CLKS));

  // R4
  precharge_met_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.rasOn) |-> rasHighCnt >= TW'(PRE_CLKS));

  // R7
  refresh_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= (TW+1)'(MAXWAIT));

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !stb.rasOn);

endmodule

// File: rtl/dram_ctl_dp.sv
module dram_ctl_dp
  import dram_ctl_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            stb,
  input  logic                  reqWrite,
  input  logic [AW-1:0]         reqAddr,
  input  logic [DW-1:0]         reqWData,
  output logic                  rdValid,
  output logic [DW-1:0]         rdData,
  output logic [AW-AW/2-1:0]    dramAddr,
  output logic                  dramRasN,
  output logic                  dramCasN,
  output logic                  dramRw,
  output logic [DW-1:0]         dramDout,
  output logic                  dramDoe,
  input  logic [DW-1:0]         dramDin
);
  localparam int COL_W = AW / 2;
  localparam int ROW_W = AW - COL_W;

  logic [ROW_W-1:0] rowReg, refRow;
  logic [COL_W-1:0] colReg;
  logic             wrReg;
  logic [DW-1:0]    wdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      wrReg  <= 1'b0;
      wdReg  <= '0;
    end else if (stb.load) begin
      rowReg <= reqAddr[AW-1:COL_W];
      colReg <= reqAddr[COL_W-1:0];
      wrReg  <= reqWrite;
      wdReg  <= reqWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) refRow <= '0;
    else if (stb.refInc) refRow <= refRow + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.capture && !wrReg;
      if (stb.capture && !wrReg) rdData <= dramDin;
    end
  end

  always_comb begin
    if (stb.useRef)      dramAddr = refRow;
    else if (stb.useCol) dramAddr = ROW_W'(colReg);
    else                 dramAddr = rowReg;
  end

  assign dramRasN = !stb.rasOn;
  assign dramCasN = !stb.casOn;
  assign dramRw   = !(stb.casOn && wrReg);
  assign dramDoe  = stb.casOn && wrReg;
  assign dramDout = wdReg;

  // R10
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);

  // R5
  ref_no_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.useRef |-> dramCasN);

endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
  import dram_ctl_pkg::*;
#(
  parameter int RCD_CLKS     = 2,
  parameter int CAS_CLKS     = 2,
  parameter int PRE_CLKS     = 2,
  parameter int REF_CLKS     = 3,
  parameter int REF_INTERVAL = 390,
  parameter int BURST_LEN    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       reqWrite,
  input  logic [13:0] reqAddr,
  input  logic [7:0] reqWData,
  output logic       rdValid,
  output logic [7:0] rdData,
  input  logic       frameEnd,
  output logic       hostIrq,
  output logic [6:0] dramAddr,
  output logic       dramRasN,
  output logic       dramCasN,
  output logic       dramRw,
  output logic [7:0] dramDout,
  output logic       dramDoe,
  input  logic [7:0] dramDin
);
  ctlStrobe_t stb;

  dram_ctl_fsm #(
    .RCD_CLKS(RCD_CLKS), .CAS_CLKS(CAS_CLKS), .PRE_CLKS(PRE_CLKS),
    .REF_CLKS(REF_CLKS), .REF_INTERVAL(REF_INTERVAL), .BURST_LEN(BURST_LEN)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .frameEnd(frameEnd),
    .reqReady(reqReady), .hostIrq(hostIrq), .stb(stb)
  );

  dram_ctl_dp #(.AW(14), .DW(8)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .rdValid(rdValid),
    .rdData(rdData), .dramAddr(dramAddr), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramRw(dramRw), .dramDout(dramDout),
    .dramDoe(dramDoe), .dramDin(dramDin)
  );

endmodule

// File: tb/dram_refresh_ctl_bench.sv
`timescale 1ns/1ps
module dram_refresh_ctl_bench;
  localparam int RCD = 2, CASC = 2, PRE = 2, REFC = 3, IVL = 40, BURST = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, frameEnd = 1'b0;
  logic [13:0] reqAddr = '0;
  logic [7:0] reqWData = '0, dramDin = '0;
  logic reqReady, rdValid, hostIrq, dramRasN, dramCasN, dramRw, dramDoe;
  logic [7:0] rdData, dramDout;
  logic [6:0] dramAddr;

  always #5 clk = ~clk;

  dram_refresh_ctl #(
    .RCD_CLKS(RCD), .CAS_CLKS(CASC), .PRE_CLKS(PRE), .REF_CLKS(REFC),
    .REF_INTERVAL(IVL), .BURST_LEN(BURST)
  ) u_dram_refresh_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData),
    .rdValid(rdValid), .rdData(rdData), .frameEnd(frameEnd), .hostIrq(hostIrq),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramRw(dramRw), .dramDout(dramDout), .dramDoe(dramDoe), .dramDin(dramDin)
  );

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural memory model, sampled on falling clock edges
  logic [7:0] mem [int];
  logic prevRas = 1'b1, prevCas = 1'b1, casSeen = 1'b0, firstRas = 1'b1;
  logic [6:0] rowLat = '0, colLat;
  int lowCnt = 0, highCnt = 0, refExp = 0, refCount = 0, accCount = 0;
  logic [13:0] curAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!dramCasN && dramRasN) chk(0, "R10 cas without ras", 0, 1);
      if (prevRas && !dramRasN) begin
        if (!firstRas) chk(highCnt >= PRE, "R4 precharge", highCnt, PRE);
        firstRas = 1'b0;
        rowLat   = dramAddr;
        casSeen  = 1'b0;
        lowCnt   = 1;
      end else if (!dramRasN) lowCnt++;
      if (dramRasN) highCnt++;
      if (prevCas && !dramCasN) begin
        chk(lowCnt > RCD, "R2 ras-to-cas", lowCnt - 1, RCD);
        chk(rowLat == curAddr[13:7], "R2 row", rowLat, curAddr[13:7]);
        chk(dramAddr == curAddr[6:0], "R2 column", dramAddr, curAddr[6:0]);
        casSeen = 1'b1;
        colLat  = dramAddr;
        if (!dramRw) mem[int'({rowLat, colLat})] = dramDout;
        else dramDin = mem.exists(int'({rowLat, colLat})) ? mem[int'({rowLat, colLat})] : 8'h00;
      end
      if (!prevRas && dramRasN) begin
        highCnt = 1;
        if (!casSeen) begin
          chk(rowLat == 7'(refExp), "R5 refresh row", rowLat, refExp % 128);
          refExp++;
          refCount++;
        end else accCount++;
      end
      prevRas = dramRasN;
      prevCas = dramCasN;
    end
  end

  task automatic doAccess(input logic wr, input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    curAddr  = a;
    reqWrite = wr;
    reqAddr  = a;
    reqWData = d;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doRead(input logic [13:0] a, input logic [7:0] exp, input string req);
    bit got = 0;
    doAccess(1'b0, a, 8'h00);
    for (int i = 0; i < 40 && !got; i++) begin
      if (rdValid) begin
        got = 1;
        chk(rdData == exp, req, rdData, exp);
      end else @(negedge clk);
    end
    if (!got) chk(0, {req, " no rdValid"}, 0, 1);
  endtask

  typedef struct packed { logic wr; logic [13:0] addr; logic [7:0] data; } vec_t;
  localparam vec_t VECS [12] = '{
    '{1'b1, 14'h0000, 8'h11}, '{1'b1, 14'h3FFF, 8'hEE},
    '{1'b1, 14'h0080, 8'h5A}, '{1'b1, 14'h0001, 8'hA5},
    '{1'b1, 14'h1234, 8'hC3}, '{1'b0, 14'h0000, 8'h11},
    '{1'b0, 14'h0080, 8'h5A}, '{1'b0, 14'h0001, 8'hA5},
    '{1'b0, 14'h3FFF, 8'hEE}, '{1'b0, 14'h1234, 8'hC3},
    '{1'b1, 14'h0000, 8'h77}, '{1'b0, 14'h0000, 8'h77}
  };

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0, a0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dramRasN && dramCasN, "R1 strobes idle", {dramRasN, dramCasN}, 3);
    chk(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    chk(!rdValid && !hostIrq, "R1 rdValid/hostIrq", {rdValid, hostIrq}, 0);

    // R3 vector walk: writes then read-back
    foreach (VECS[i]) begin
      if (VECS[i].wr) doAccess(1'b1, VECS[i].addr, VECS[i].data);
      else doRead(VECS[i].addr, VECS[i].data, "R3 read data");
    end

    // R6 periodic refresh rate over ten intervals
    repeat (20) @(negedge clk);
    r0 = refCount;
    repeat (10 * IVL) @(negedge clk);
    chk((refCount - r0) >= 9 && (refCount - r0) <= 11, "R6 refresh rate",
        refCount - r0, 10);

    // R8 frame end: interrupt pulse and refresh burst; R9 ready drops
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    r0 = refCount;
    a0 = accCount;
    chk(hostIrq == 1'b1, "R8 hostIrq raised", hostIrq, 1);
    chk(reqReady == 1'b0, "R9 reqReady low with refresh owed", reqReady, 0);
    @(negedge clk);
    chk(hostIrq == 1'b0, "R8 hostIrq one cycle", hostIrq, 0);
    // R7 request behind the burst waits for all refreshes
    doAccess(1'b1, 14'h2A55, 8'h3C);
    for (int i = 0; i < 200 && accCount == a0; i++) @(negedge clk);
    chk(accCount == a0 + 1, "R7 access completed", accCount - a0, 1);
    chk((refCount - r0) >= BURST, "R8 burst before access", refCount - r0, BURST);
    doRead(14'h2A55, 8'h3C, "R3 read after burst");

    // R5 refresh counter wrap past 127
    while (refCount <= 130) @(negedge clk);
    chk(refExp > 128, "R5 refresh row wrap reached", refExp, 129);
    doRead(14'h3FFF, 8'hEE, "R3 data held across refresh");

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule